// File: doc/BRIEF.md
# USB Host Pipe Configuration Checker

This block keeps the configuration words of seven USB host pipes and decides, pipe by pipe, whether each one may carry traffic. Software sets up a pipe through a simple register port. It turns the pipe on, fills in the endpoint, transfer type, token, packet size code, bank count and polling interval, and then raises an allocate bit. On the next clock the block checks the request. The packet size and bank count must lie within that pipe's own limits, and the buffer space the pipe asks for must fit into what is left of a shared 2048-byte buffer memory. The result is written to a config-ok flag that software reads back.

Pipes claim buffer memory in index order, from pipe 0 upward. A pipe that fails its check claims nothing, so a smaller request at a higher index can still fit. While config-ok is clear, send requests on that pipe are blocked, and a pipe that is enabled and allocated but not ok raises an error flag. While config-ok is set, the pipe's layout is frozen: writes can change only the token, the polling interval, and the enable and allocate bits. Clearing enable or allocate gives the memory back and unfreezes the fields.

Top module: `usb_pipe_cfg`

## Requirements
- R1: A pipe's config-ok is set exactly when the pipe is enabled and allocated, its request passes its own limits, and its size in bytes (8 << size code) times its bank count fits in the memory left after all passing lower-index pipes. The limit is a 2048-byte total. A pipe that fails consumes no memory. config-ok reflects the configuration registered on the previous clock edge.
- R2: send_grant_o[i] is high only while send_req_i[i], config-ok of pipe i, enable and allocate are all high. Otherwise it is low.
- R3: While config-ok of a pipe is 1, a write to that pipe updates only enable (bit 0), allocate (bit 1), token (bits 10:9) and interval (bits 22:15). Endpoint (14:11), type (8:7), size code (4:2) and bank code (6:5) keep their values.
- R4: Read bits 30:23 return the polling interval when the type code is 3 (interrupt) and zero for any other type.
- R5: A read of pipe i returns the stored configuration in bits 22:0, using the write layout, with config-ok in bit 31. A read of index 7 returns zero.
- R6: Pipe 0 accepts at most size code 3 (64 bytes) and one bank. Pipes 1 to 6 accept at most size code 5 (256 bytes) and three banks.
- R7: The bank code stores the bank count minus one. Code 3 is illegal and keeps config-ok at 0.
- R8: When enable or allocate is cleared, config-ok drops on the next edge, the memory is freed for higher pipes, and all fields become writable again.
- R9: pipe_err_o[i] is high when pipe i was enabled and allocated on the previous edge but failed its check. It is never high together with config-ok.
- R10: Reset clears every configuration field, config-ok flag and error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_pipe_i | input | 3 | Pipe index of the write |
| wr_data_i | input | 23 | Configuration word to write |
| rd_pipe_i | input | 3 | Pipe index of the read |
| rd_data_o | output | 32 | Read word: configuration, effective interval and config-ok |
| send_req_i | input | 7 | Per-pipe send request |
| send_grant_o | output | 7 | Per-pipe send permission |
| pipe_err_o | output | 7 | Per-pipe configuration error flag |

## Verification
The hardest case to reach is one where memory exhaustion and release interact. A high pipe must fail only because lower pipes have used up the memory, a later pipe must still fit in what remains, and freeing a lower pipe must then let the failed pipe pass. The stimulus stacks several 768-byte requests on pipes 1 to 3 behind a 64-byte pipe 0 and adds a 256-byte request on pipe 4. It then disables pipe 2 and re-reads pipe 3. A behavioural model in the bench tracks every pipe on every clock, and it also catches writes that land in the same cycle as the flag update.

// File: rtl/usb_pipe_cfg_pkg.sv
`timescale 1ns/1ps
package usb_pipe_cfg_pkg;
  localparam logic [1:0] TYPE_INTR = 2'd3;
  localparam logic [1:0] BANK_BAD  = 2'd3;

  typedef struct packed {
    logic [7:0] ivl;
    logic [3:0] ep;
    logic [1:0] tok;
    logic [1:0] typ;
    logic [1:0] bk;
    logic [2:0] sz;
    logic       alloc;
    logic       en;
  } pipe_cfg_t;

  localparam int CFG_W = $bits(pipe_cfg_t);
endpackage

// File: rtl/usb_pipe_cfg_reg.sv
`timescale 1ns/1ps
module usb_pipe_cfg_reg
  import usb_pipe_cfg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  pipe_cfg_t wr_data_i,
  input  logic      lock_i,
  output pipe_cfg_t cfg_o
);
  pipe_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_en_i) begin
      if (lock_i) begin
        // frozen layout: only these stay writable
        cfg_q.en    <= wr_data_i.en;
        cfg_q.alloc <= wr_data_i.alloc;
        cfg_q.tok   <= wr_data_i.tok;
        cfg_q.ivl   <= wr_data_i.ivl;
      end else begin
        cfg_q <= wr_data_i;
      end
    end
  end

  assign cfg_o = cfg_q;

  AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable({cfg_q.ep, cfg_q.typ, cfg_q.sz, cfg_q.bk})); // R3
endmodule

// File: rtl/usb_pipe_alloc_chk.sv
`timescale 1ns/1ps
module usb_pipe_alloc_chk #(
  parameter int NUM_PIPES = 7,
  parameter int MEM_BYTES = 2048,
  parameter int P0_MAX_SZ = 3,
  parameter int P0_MAX_BK = 1,
  parameter int PN_MAX_SZ = 5,
  parameter int PN_MAX_BK = 3
) (
  input  logic [NUM_PIPES-1:0]      req_i,
  input  logic [NUM_PIPES-1:0][2:0] sz_i,
  input  logic [NUM_PIPES-1:0][1:0] bk_i,
  output logic [NUM_PIPES-1:0]      fit_o
);
  localparam int USE_W = $clog2(MEM_BYTES + 3 * 1024) + 1;

  logic [USE_W-1:0] used;
  logic [USE_W-1:0] need;
  logic [2:0]       mx_sz;
  int               mx_bk;

  // index-ordered first-fit over the shared buffer
  always_comb begin
    used  = '0;
    need  = '0;
    mx_sz = '0;
    mx_bk = 0;
    fit_o = '0;
    for (int i = 0; i < NUM_PIPES; i++) begin
      mx_sz = (i == 0) ? 3'(P0_MAX_SZ) : 3'(PN_MAX_SZ);
      mx_bk = (i == 0) ? P0_MAX_BK : PN_MAX_BK;
      need  = (USE_W'(8) << sz_i[i]) * (USE_W'(bk_i[i]) + USE_W'(1));
      if (req_i[i] && bk_i[i] != usb_pipe_cfg_pkg::BANK_BAD &&
          sz_i[i] <= mx_sz && (int'(bk_i[i]) + 1) <= mx_bk &&
          (used + need) <= USE_W'(MEM_BYTES)) begin
        fit_o[i] = 1'b1;
        used     = used + need;
      end
    end
  end
endmodule

// File: rtl/usb_pipe_cfg.sv
`timescale 1ns/1ps
module usb_pipe_cfg
  import usb_pipe_cfg_pkg::*;
#(
  parameter int NUM_PIPES = 7,
  parameter int MEM_BYTES = 2048,
  parameter int P0_MAX_SZ = 3,
  parameter int P0_MAX_BK = 1,
  parameter int PN_MAX_SZ = 5,
  parameter int PN_MAX_BK = 3,
  localparam int PIPE_W   = $clog2(NUM_PIPES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [PIPE_W-1:0]    wr_pipe_i,
  input  logic [CFG_W-1:0]     wr_data_i,
  input  logic [PIPE_W-1:0]    rd_pipe_i,
  output logic [31:0]          rd_data_o,
  input  logic [NUM_PIPES-1:0] send_req_i,
  output logic [NUM_PIPES-1:0] send_grant_o,
  output logic [NUM_PIPES-1:0] pipe_err_o
);
  pipe_cfg_t [NUM_PIPES-1:0]      cfg;
  logic [NUM_PIPES-1:0]           active;
  logic [NUM_PIPES-1:0][2:0]      sz_v;
  logic [NUM_PIPES-1:0][1:0]      bk_v;
  logic [NUM_PIPES-1:0]           fit;
  logic [NUM_PIPES-1:0]           ok_q;
  logic [NUM_PIPES-1:0]           err_q;

  for (genvar g = 0; g < NUM_PIPES; g++) begin : g_pipe
    usb_pipe_cfg_reg u_reg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i && (wr_pipe_i == PIPE_W'(g))),
      .wr_data_i (pipe_cfg_t'(wr_data_i)),
      .lock_i    (ok_q[g]),
      .cfg_o     (cfg[g])
    );
    assign active[g] = cfg[g].en & cfg[g].alloc;
    assign sz_v[g]   = cfg[g].sz;
    assign bk_v[g]   = cfg[g].bk;

    AST_RELEASE_DROPS_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !active[g] |=> !ok_q[g]); // R8

    AST_BANK_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ok_q[g] && $past(ok_q[g])) |-> (cfg[g].bk != BANK_BAD)); // R7
  end

  usb_pipe_alloc_chk #(
    .NUM_PIPES (NUM_PIPES),
    .MEM_BYTES (MEM_BYTES),
    .P0_MAX_SZ (P0_MAX_SZ),
    .P0_MAX_BK (P0_MAX_BK),
    .PN_MAX_SZ (PN_MAX_SZ),
    .PN_MAX_BK (PN_MAX_BK)
  ) u_chk (
    .req_i (active),
    .sz_i  (sz_v),
    .bk_i  (bk_v),
    .fit_o (fit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q  <= '0;
      err_q <= '0;
    end else begin
      ok_q  <= fit;
      err_q <= active & ~fit;
    end
  end

  assign send_grant_o = send_req_i & ok_q & active;
  assign pipe_err_o   = err_q;

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_PIPES; i++) begin
      if (rd_pipe_i == PIPE_W'(i)) begin
        rd_data_o[CFG_W-1:0] = cfg[i];
        rd_data_o[30:23]     = (cfg[i].typ == TYPE_INTR) ? cfg[i].ivl : 8'd0;
        rd_data_o[31]        = ok_q[i];
      end
    end
  end

  AST_GRANT_NEEDS_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_grant_o & ~ok_q) == '0); // R2

  AST_OK_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_q & err_q) == '0); // R9

  AST_P0_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_q[0] && $past(ok_q[0])) |->
      (cfg[0].sz <= 3'(P0_MAX_SZ) && (int'(cfg[0].bk) + 1) <= P0_MAX_BK)); // R6
endmodule

// File: tb/usb_pipe_cfg_tb_top.sv
`timescale 1ns/1ps
module usb_pipe_cfg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_pipe = '0;
  logic [22:0] wr_data = '0;
  logic [2:0]  rd_pipe = '0;
  logic [31:0] rd_data;
  logic [6:0]  send_req = '0;
  logic [6:0]  grant;
  logic [6:0]  perr;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  usb_pipe_cfg dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_pipe_i(wr_pipe), .wr_data_i(wr_data),
    .rd_pipe_i(rd_pipe), .rd_data_o(rd_data),
    .send_req_i(send_req), .send_grant_o(grant), .pipe_err_o(perr)
  );

  // behavioural reference model
  logic [22:0] m_cfg [7] = '{default: '0};
  logic [6:0]  m_ok  = '0;
  logic [6:0]  m_err = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 7; p++) m_cfg[p] = '0;
      m_ok = '0; m_err = '0;
    end else begin
      int used;
      logic [6:0] nok, nerr;
      used = 0; nok = '0; nerr = '0;
      for (int p = 0; p < 7; p++) begin
        int bytes, banks, lim_b, lim_k;
        bit req, pass;
        req   = m_cfg[p][0] && m_cfg[p][1];
        bytes = 8 << m_cfg[p][4:2];
        banks = int'(m_cfg[p][6:5]) + 1;
        lim_b = (p == 0) ? 64 : 256;
        lim_k = (p == 0) ? 1 : 3;
        pass  = req && banks <= 3 && bytes <= lim_b && banks <= lim_k &&
                used + bytes * banks <= 2048;
        if (pass) used += bytes * banks;
        nok[p]  = pass;
        nerr[p] = req && !pass;
      end
      if (wr_en && wr_pipe < 7) begin
        if (m_ok[wr_pipe]) begin
          m_cfg[wr_pipe][1:0]   = wr_data[1:0];
          m_cfg[wr_pipe][10:9]  = wr_data[10:9];
          m_cfg[wr_pipe][22:15] = wr_data[22:15];
        end else begin
          m_cfg[wr_pipe] = wr_data;
        end
      end
      m_ok = nok; m_err = nerr;
    end
  end

  function automatic logic [31:0] exp_rd(int p);
    if (p >= 7) return '0;
    return {m_ok[p], (m_cfg[p][8:7] == 2'd3) ? m_cfg[p][22:15] : 8'd0, m_cfg[p]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    chk("R5 model readback", rd_data, exp_rd(int'(rd_pipe)));
    chk("R2 model grant", 32'(grant), 32'(send_req & m_ok & {
      m_cfg[6][0] & m_cfg[6][1], m_cfg[5][0] & m_cfg[5][1], m_cfg[4][0] & m_cfg[4][1],
      m_cfg[3][0] & m_cfg[3][1], m_cfg[2][0] & m_cfg[2][1], m_cfg[1][0] & m_cfg[1][1],
      m_cfg[0][0] & m_cfg[0][1]}));
    chk("R9 model err", 32'(perr), 32'(m_err));
  end

  function automatic logic [22:0] cw(int en, int al, int sz, int bk, int ty,
                                     int tk, int ep, int iv);
    return {8'(iv), 4'(ep), 2'(tk), 2'(ty), 2'(bk), 3'(sz), 1'(al), 1'(en)};
  endfunction

  task automatic wr(int p, logic [22:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_pipe = 3'(p); wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic peek(int p);
    @(posedge clk); #1;
    rd_pipe = 3'(p);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int p = 0; p < 7; p++) begin
      peek(p);
      chk("R10 reset word", rd_data, 32'h0);
    end
    chk("R10 reset err", 32'(perr), 32'h0);

    // R1: pipe1 256B x3 fits
    wr(1, cw(1,1,5,2,2,2,3,0));
    peek(1);
    chk("R1 pipe1 ok", 32'(rd_data[31]), 32'd1);
    chk("R9 pipe1 no err", 32'(perr[1]), 32'd0);

    // R6: pipe0 size 128 rejected, two banks rejected, 64x1 accepted
    wr(0, cw(1,1,4,0,0,0,0,0));
    peek(0);
    chk("R6 pipe0 size", 32'(rd_data[31]), 32'd0);
    chk("R9 pipe0 err", 32'(perr[0]), 32'd1);
    wr(0, cw(1,1,3,1,0,0,0,0));
    peek(0);
    chk("R6 pipe0 banks", 32'(rd_data[31]), 32'd0);
    wr(0, cw(1,0,3,0,0,0,0,0));
    wr(0, cw(1,1,3,0,0,0,0,0));
    peek(0);
    chk("R6 pipe0 64x1 ok", 32'(rd_data[31]), 32'd1);

    // R7: bank code 3 illegal
    wr(2, cw(1,1,0,3,2,0,0,0));
    peek(2);
    chk("R7 bank code 3", 32'(rd_data[31]), 32'd0);
    chk("R7 err flag", 32'(perr[2]), 32'd1);
    wr(2, cw(1,1,5,2,2,0,1,0));
    peek(2);
    chk("R1 pipe2 fits 1600", 32'(rd_data[31]), 32'd1);

    // R1: pipe3 exceeds memory, pipe4 fits behind it
    wr(3, cw(1,1,5,2,2,0,2,0));
    wr(4, cw(1,1,5,0,2,0,4,0));
    peek(3);
    chk("R1 pipe3 no memory", 32'(rd_data[31]), 32'd0);
    peek(4);
    chk("R1 pipe4 fits", 32'(rd_data[31]), 32'd1);

    // R8: release pipe2, pipe3 now fits
    wr(2, cw(0,0,5,2,2,0,1,0));
    peek(3);
    chk("R8 pipe3 after release", 32'(rd_data[31]), 32'd1);
    peek(2);
    chk("R8 pipe2 ok cleared", 32'(rd_data[31]), 32'd0);

    // R2: grants follow ok (pipes 0,1,3,4)
    @(posedge clk); #1 send_req = 7'h7F;
    @(negedge clk);
    chk("R2 grant all req", 32'(grant), 32'h1B);
    @(posedge clk); #1 send_req = 7'h55;
    @(negedge clk);
    chk("R2 grant mixed", 32'(grant), 32'h11);
    @(posedge clk); #1 send_req = 7'h00;

    // R3/R4: locked pipe1 keeps layout, token and interval change
    wr(1, cw(1,1,0,0,3,1,9,7));
    peek(1);
    chk("R3 locked fields", 32'(rd_data[22:0]), 32'(cw(1,1,5,2,2,1,3,7)));
    chk("R4 bulk interval", 32'(rd_data[30:23]), 32'd0);
    chk("R3 still ok", 32'(rd_data[31]), 32'd1);

    // R4: interrupt pipe reports interval
    wr(5, cw(1,1,2,0,3,1,2,20));
    peek(5);
    chk("R4 intr interval", 32'(rd_data[30:23]), 32'd20);
    chk("R1 pipe5 ok", 32'(rd_data[31]), 32'd1);

    // R8: unlock then rewrite layout
    wr(1, cw(1,0,5,2,2,1,3,7));
    peek(1);
    chk("R8 dealloc clears ok", 32'(rd_data[31]), 32'd0);
    wr(1, cw(1,0,1,0,1,2,12,0));
    peek(1);
    chk("R8 unlocked write", 32'(rd_data[22:0]), 32'(cw(1,0,1,0,1,2,12,0)));

    // R5: unused index reads zero
    peek(7);
    chk("R5 index 7", rd_data, 32'h0);

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule